// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned operands of a parameterised width together with a single carry input. It returns the low result bits and the carry out of the top position. Carries are not rippled. Each bit first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). These terms are summarised in groups of four bits. Groups of four groups are summarised again into 16-bit blocks. A top lookahead over the blocks then hands a carry down to every block, every group and every bit in parallel. The number of logic levels on the carry path therefore grows with the logarithm of the width.

A build-time switch picks one of two forms. The first is purely combinational: results follow the operands in the same cycle. The second places one register bank on the carry path. The cut sits after the per-bit terms and the 4-bit group summaries, and before the block and top lookahead levels. A valid flag travels with the data through the cut. In this form a new addition may enter on every clock, and each result comes out one clock after it was accepted.

Top module: `cla_adder`

## Requirements
- R1: When a result is presented, `sum` equals the low WIDTH bits of a + b + cin.
- R2: When a result is presented, `cout` equals bit WIDTH of a + b + cin. Example: the MSBs of both operands set and all other bits clear gives `cout`=1 and `sum`=0.
- R3: A carry entering at bit 0 crosses every position. All-ones + 1 with cin=0 gives `sum`=0 and `cout`=1. All-ones + 0 with cin=1 gives the same result.
- R4: A carry generated in the lowest group crosses groups that only propagate. Example: 0x7FFFFFFF + 1 yields 0x80000000 with `cout`=0.
- R5: Alternating-bit operands are summed exactly. Example: 0xAA..A + 0x55..5 with cin=1 wraps to zero with `cout`=1.
- R6: With PIPELINE=1, each input accepted with `in_valid` high at a rising clock edge yields `out_valid`=1 and its result after that same edge. Accepted inputs may arrive on every cycle.
- R7: With PIPELINE=1, `out_valid` is 0 while `rst_n` is low. It is also 0 after any edge at which `in_valid` was low.
- R8: With PIPELINE=0, results follow the operands combinationally in the same cycle, and `out_valid` equals `in_valid`.
- R9: WIDTH is a multiple of 16 from 16 to 64; both 32-bit and 64-bit instances produce correct results.
- R10: When group k generates, the carry into group k+1 is 1. When group k neither generates nor propagates, that carry is 0. Example: 0xF0 + 0x10 = 0x100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline register bank |
| rst_n | input | 1 | Asynchronous active-low reset; clears only the valid flag |
| in_valid | input | 1 | Operands and carry input are meaningful this cycle |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | `sum` and `cout` hold a result |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The pipelined 32-bit instance has a latency of exactly one rising edge. The bench changes operands on the falling edge and reads `out_valid`, `sum` and `cout` 2 ns after the next rising edge. Because each addition is read before the next one is driven, back-to-back vectors stay aligned with their results. The combinational 64-bit instance has no latency. It is driven alongside the pipelined one and checked 2 ns after its inputs change, within the same cycle. Checks on idle input and on reset sample `out_valid` after the edge or after the asynchronous reset falls, before any new stimulus.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned GRP_BITS = 4;
  localparam int unsigned BLK_BITS = 16;

  // Summary "this slice creates a carry on its own".
  function automatic logic grp_gen(input logic [GRP_BITS-1:0] g,
                                   input logic [GRP_BITS-1:0] p);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < GRP_BITS; j++) begin
      term = g[j];
      for (int m = j + 1; m < GRP_BITS; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  // Summary "an incoming carry passes straight through this slice".
  function automatic logic grp_prop(input logic [GRP_BITS-1:0] p);
    return &p;
  endfunction

endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead: carry into each of N positions and the
// carry out, all from the local g/p terms and one carry input.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] c,
  output logic         co
);

  logic [N:0] c_all;

  always_comb begin
    logic acc;
    logic term;
    for (int k = 0; k <= N; k++) begin
      term = cin;
      for (int m = 0; m < k; m++) term = term & p[m];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        acc = acc | term;
      end
      c_all[k] = acc;
    end
  end

  assign c  = c_all[N-1:0];
  assign co = c_all[N];

  always_comb begin
    for (int k = 1; k < N; k++) begin
      if (g[k-1]) begin
        AST_LAH_GEN: assert (c[k] == 1'b1); // R10
      end
      if (!g[k-1] && !p[k-1]) begin
        AST_LAH_KILL: assert (c[k] == 1'b0); // R10
      end
    end
  end

endmodule

// File: rtl/cla_pg_stage.sv
// Per-bit generate/propagate and 4-bit group summaries.
module cla_pg_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]            a,
  input  logic [WIDTH-1:0]            b,
  output logic [WIDTH-1:0]            g,
  output logic [WIDTH-1:0]            p,
  output logic [WIDTH/cla_pkg::GRP_BITS-1:0] gg,
  output logic [WIDTH/cla_pkg::GRP_BITS-1:0] gp
);

  localparam int unsigned GB = cla_pkg::GRP_BITS;
  localparam int unsigned NG = WIDTH / GB;

  assign g = a & b;
  assign p = a ^ b;

  for (genvar i = 0; i < NG; i++) begin : g_grp
    assign gg[i] = cla_pkg::grp_gen(g[i*GB +: GB], p[i*GB +: GB]);
    assign gp[i] = cla_pkg::grp_prop(p[i*GB +: GB]);
  end

endmodule

// File: rtl/cla_carry_tree.sv
// Levels two and three: group summaries -> block summaries -> top lookahead,
// then block carries fanned back down to every group.
module cla_carry_tree #(
  parameter int unsigned NG = 8
) (
  input  logic [NG-1:0] grp_g,
  input  logic [NG-1:0] grp_p,
  input  logic          cin,
  output logic [NG-1:0] grp_c,
  output logic          cout
);

  localparam int unsigned GB = cla_pkg::GRP_BITS;
  localparam int unsigned NB = NG / GB;

  logic [NB-1:0] blk_g;
  logic [NB-1:0] blk_p;
  logic [NB-1:0] blk_c;
  logic [NB-1:0] blk_co;

  for (genvar bk = 0; bk < NB; bk++) begin : g_blk
    assign blk_g[bk] = cla_pkg::grp_gen(grp_g[bk*GB +: GB], grp_p[bk*GB +: GB]);
    assign blk_p[bk] = cla_pkg::grp_prop(grp_p[bk*GB +: GB]);

    cla_lookahead #(.N(GB)) u_l2 (
      .g   (grp_g[bk*GB +: GB]),
      .p   (grp_p[bk*GB +: GB]),
      .cin (blk_c[bk]),
      .c   (grp_c[bk*GB +: GB]),
      .co  (blk_co[bk])
    );
  end

  cla_lookahead #(.N(NB)) u_l3 (
    .g   (blk_g),
    .p   (blk_p),
    .cin (cin),
    .c   (blk_c),
    .co  (cout)
  );

  always_comb begin
    for (int k = 0; k + 1 < NB; k++) begin
      AST_BLK_HANDOFF: assert (blk_co[k] == blk_c[k+1]); // R10
    end
    AST_BLK_TOP: assert (blk_co[NB-1] == cout); // R2
  end

endmodule

// File: rtl/cla_sum_stage.sv
// Level one downward pass: carries inside each group and the sum bits.
module cla_sum_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]                   g,
  input  logic [WIDTH-1:0]                   p,
  input  logic [WIDTH/cla_pkg::GRP_BITS-1:0] grp_c,
  output logic [WIDTH-1:0]                   sum,
  output logic                               top_co
);

  localparam int unsigned GB = cla_pkg::GRP_BITS;
  localparam int unsigned NG = WIDTH / GB;

  logic [WIDTH-1:0] bit_c;
  logic [NG-1:0]    grp_co;

  for (genvar i = 0; i < NG; i++) begin : g_grp
    cla_lookahead #(.N(GB)) u_l1 (
      .g   (g[i*GB +: GB]),
      .p   (p[i*GB +: GB]),
      .cin (grp_c[i]),
      .c   (bit_c[i*GB +: GB]),
      .co  (grp_co[i])
    );
  end

  assign sum    = p ^ bit_c;
  assign top_co = grp_co[NG-1];

  always_comb begin
    for (int i = 0; i + 1 < NG; i++) begin
      AST_GRP_HANDOFF: assert (grp_co[i] == grp_c[i+1]); // R10
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH    = 32,
  parameter bit          PIPELINE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NG = WIDTH / cla_pkg::GRP_BITS;

  if ((WIDTH % cla_pkg::BLK_BITS) != 0 || WIDTH < 16 || WIDTH > 64) begin : g_bad_width
    $error("cla_adder: WIDTH must be 16, 32, 48 or 64");
  end

  // Stage 1: per-bit terms and group summaries.
  logic [WIDTH-1:0] s1_g, s1_p;
  logic [NG-1:0]    s1_gg, s1_gp;

  cla_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a  (a),
    .b  (b),
    .g  (s1_g),
    .p  (s1_p),
    .gg (s1_gg),
    .gp (s1_gp)
  );

  // Cut point.
  logic [WIDTH-1:0] s2_g, s2_p;
  logic [NG-1:0]    s2_gg, s2_gp;
  logic             s2_cin;

  if (PIPELINE) begin : g_pipe
    logic             valid_q, valid_d;
    logic             load_en;
    logic [WIDTH-1:0] g_q, p_q;
    logic [NG-1:0]    gg_q, gp_q;
    logic             cin_q;

    always_comb begin
      valid_d = in_valid;
      load_en = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        g_q   <= s1_g;
        p_q   <= s1_p;
        gg_q  <= s1_gg;
        gp_q  <= s1_gp;
        cin_q <= cin;
      end
    end

    assign s2_g      = g_q;
    assign s2_p      = p_q;
    assign s2_gg     = gg_q;
    assign s2_gp     = gp_q;
    assign s2_cin    = cin_q;
    assign out_valid = valid_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R6
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
    AST_RESULT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)}
                                     + {{WIDTH{1'b0}}, $past(cin)}))); // R1
  end else begin : g_comb
    assign s2_g      = s1_g;
    assign s2_p      = s1_p;
    assign s2_gg     = s1_gg;
    assign s2_gp     = s1_gp;
    assign s2_cin    = cin;
    assign out_valid = in_valid;
  end

  // Stage 2: upper lookahead levels and sum formation.
  logic [NG-1:0] grp_c;
  logic          tree_co;
  logic          grp_top_co;

  cla_carry_tree #(.NG(NG)) u_tree (
    .grp_g (s2_gg),
    .grp_p (s2_gp),
    .cin   (s2_cin),
    .grp_c (grp_c),
    .cout  (tree_co)
  );

  cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .g      (s2_g),
    .p      (s2_p),
    .grp_c  (grp_c),
    .sum    (sum),
    .top_co (grp_top_co)
  );

  assign cout = tree_co;

  always_comb begin
    AST_COUT_PATHS: assert (grp_top_co == tree_co); // R2
  end

endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic [31:0] a, b;
  logic        cin;
  logic        out_valid;
  logic [31:0] sum;
  logic        cout;

  logic [63:0] wa, wb;
  logic        wcin;
  logic        w_valid;
  logic [63:0] w_sum;
  logic        w_cout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  cla_adder #(.WIDTH(32), .PIPELINE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .cin(cin),
    .out_valid(out_valid), .sum(sum), .cout(cout)
  );

  cla_adder #(.WIDTH(64), .PIPELINE(1'b0)) dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(wa), .b(wb), .cin(wcin),
    .out_valid(w_valid), .sum(w_sum), .cout(w_cout)
  );

  function automatic logic [32:0] ref32(input logic [31:0] x, input logic [31:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  function automatic logic [64:0] ref64(input logic [63:0] x, input logic [63:0] y,
                                        input logic c);
    return {1'b0, x} + {1'b0, y} + {64'd0, c};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one addition on both instances; wide result checked in-cycle,
  // pipelined result checked after the next rising edge.
  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic c,
                     input logic [63:0] wx, input logic [63:0] wy, input logic wc,
                     input string req);
    logic [32:0] e32;
    logic [64:0] e64;
    e32 = ref32(x, y, c);
    e64 = ref64(wx, wy, wc);
    @(negedge clk);
    in_valid = 1'b1;
    a = x; b = y; cin = c;
    wa = wx; wb = wy; wcin = wc;
    #2;
    check({w_cout, w_sum} == e64, {req, " R8 R9 wide"}, {w_cout, w_sum}, e64);
    check(w_valid == 1'b1, "R8 valid", {64'd0, w_valid}, 65'd1);
    @(posedge clk);
    #2;
    check(out_valid == 1'b1, "R6 out_valid", {64'd0, out_valid}, 65'd1);
    check({cout, sum} == e32, {req, " R1 R2"}, {32'd0, cout, sum}, {32'd0, e32});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx, ry;
    logic [63:0] rwx, rwy;
    rst_n = 1'b0; in_valid = 1'b0;
    a = '0; b = '0; cin = 1'b0; wa = '0; wb = '0; wcin = 1'b0;
    void'($urandom(32'd20240917));

    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R7 reset", {64'd0, out_valid}, 65'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: carry crosses the whole width
    run(32'hFFFF_FFFF, 32'h1, 1'b0, '1, 64'h1, 1'b0, "R3 ones+1");
    run(32'hFFFF_FFFF, 32'h0, 1'b1, '1, 64'h0, 1'b1, "R3 ones+cin");
    // R4: carry from low group through propagating groups
    run(32'h7FFF_FFFF, 32'h1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, "R4 skip");
    // R5: alternating bit patterns
    run(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, {4{16'hAAAA}}, {4{16'h5555}}, 1'b1, "R5 alt wrap");
    run(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, {4{16'hAAAA}}, {4{16'hAAAA}}, 1'b0, "R5 alt double");
    run(32'h5555_5555, 32'h5555_5555, 1'b1, {4{16'h5555}}, {4{16'h5555}}, 1'b1, "R5 alt odd");
    // R2: top-bit carry only
    run(32'h8000_0000, 32'h8000_0000, 1'b0, 64'h8000_0000_0000_0000,
        64'h8000_0000_0000_0000, 1'b0, "R2 msb");
    // R10: group generate and group kill
    run(32'h0000_00F0, 32'h0000_0010, 1'b0, 64'hF0, 64'h10, 1'b0, "R10 gen");
    run(32'h0F0F_0F0F, 32'h0000_0000, 1'b1, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 1'b1, "R10 kill");

    // R1 / R6: back-to-back random vectors
    for (int i = 0; i < 300; i++) begin
      rx = $urandom; ry = $urandom;
      rwx = {$urandom, $urandom}; rwy = {$urandom, $urandom};
      run(rx, ry, rx[3] ^ ry[7], rwx, rwy, rwx[11], "R1 random");
    end

    // R7: idle cycle gives no result
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    check(w_valid == 1'b0, "R8 idle", {64'd0, w_valid}, 65'd0);
    @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R7 idle", {64'd0, out_valid}, 65'd0);

    // R7: asynchronous reset during traffic
    run(32'h1234_5678, 32'h0FED_CBA9, 1'b0, 64'h1, 64'h2, 1'b0, "R1 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(out_valid == 1'b0, "R7 async reset", {64'd0, out_valid}, 65'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run(32'hDEAD_BEEF, 32'h2152_4111, 1'b1, 64'hFFFF_0000_FFFF_0000,
        64'h0001_0000_0001_0000, 1'b0, "R1 post-reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule